// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register storage of a 32-bit processor core. It gives the pipeline two combinational read ports and one write port, all addressed by a 5-bit architectural register number. Numbers 0 to 7 select eight global registers that every procedure shares. Numbers 8 to 31 select 24 registers inside the current window, which a current-window pointer chooses. Each window has eight outgoing, eight local and eight incoming registers. Adjacent windows overlap: the incoming registers of one window are the same storage as the outgoing registers of the window above it. The windows form a ring of `NWIN` windows, so they wrap around.

A save command moves the pointer one window down, and a restore command moves it one window up. Before it moves, the block looks at the destination window in a window-invalid mask. If that bit is set, the move is refused and the block raises an overflow trap (for a save) or an underflow trap (for a restore). The trap handler that spills or fills windows is outside this block. A separate control port loads and shows the pointer and the mask.

Top module: `regwin_rf`

## Requirements
- R1: Architectural registers 1 to 7 map to eight global entries that are the same for every window pointer value.
- R2: Register 0 always reads as zero on both ports, and a write to it changes nothing.
- R3: For register numbers 8 to 31, offset k = number − 8 maps to ring slot (16·cwp + k) mod 16·NWIN. As a result, the incoming registers 24 to 31 of window w are the outgoing registers 8 to 15 of window (w+1) mod NWIN, including the wrap from NWIN−1 to 0. No other registers of different windows share storage.
- R4: A save loads cwp with (cwp − 1) mod NWIN, and a restore loads it with (cwp + 1) mod NWIN, at the next rising clock edge. When save and restore arrive together, only the save acts.
- R5: When the mask bit at the destination index of a save is set, trap_ovf is high in that cycle. When the mask bit at the destination index of a restore is set, trap_unf is high in that cycle. In either case cwp keeps its value.
- R6: A register write presented in a cycle that raises either trap is discarded.
- R7: When a read and a write address the same register in the same cycle, the read returns the data being written.
- R8: ctl_wr_cwp loads cwp from the low log2(NWIN) bits of ctl_wdata. ctl_wr_wim loads the mask from ctl_wdata, with bit i guarding window i. A pointer load takes precedence over a save or restore in the same cycle.
- R9: While reset is held and after it is removed, cwp is NWIN−1, the mask is zero and both traps are low. Removal of reset is synchronised to clk and takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| win_save | input | 1 | Move to the window below |
| win_restore | input | 1 | Move to the window above |
| trap_ovf | output | 1 | Save refused by the mask |
| trap_unf | output | 1 | Restore refused by the mask |
| ctl_wr_cwp | input | 1 | Load the window pointer |
| ctl_wr_wim | input | 1 | Load the invalid mask |
| ctl_wdata | input | NWIN | Control write data |
| cwp_o | output | log2(NWIN) | Current window pointer |
| wim_o | output | NWIN | Current invalid mask |

## Verification
The bench builds the block with NWIN = 4, which gives 72 physical entries. At that size it can write a distinct value to every register number in every window and then read all 32 numbers back through both ports from every window. This sweep covers every alias of the overlap, the wrap from the top window to window 0, and the sharing of the globals. Small pointer and mask widths also let it step save, restore and their combinations from every pointer value, and place a mask bit so that both trap directions and the discarded write are hit.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned NGLOBAL = 8;
  localparam int unsigned WINSTEP = 16;
  localparam int unsigned AW      = 5;

  typedef enum logic [1:0] {
    WIN_HOLD    = 2'd0,
    WIN_DOWN    = 2'd1,
    WIN_UP      = 2'd2,
    WIN_LOAD    = 2'd3
  } win_op_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CWPW  = $clog2(NWIN),
  localparam int unsigned RINGW = CWPW + 4,
  localparam int unsigned NPHYS = NGLOBAL + WINSTEP * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS)
) (
  input  logic [AW-1:0]   arch,
  input  logic [CWPW-1:0] cwp,
  output logic [PW-1:0]   phys
);
  logic [RINGW-1:0] ring;

  // slot in the ring wraps modulo 16*NWIN because NWIN is a power of two
  always_comb begin
    ring = {cwp, 4'b0000} + RINGW'(arch) - RINGW'(NGLOBAL);
    if (arch < AW'(NGLOBAL)) phys = PW'(arch);
    else                     phys = PW'(NGLOBAL) + PW'(ring);
  end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save,
  input  logic            restore,
  input  logic            ld_cwp,
  input  logic            ld_wim,
  input  logic [NWIN-1:0] ld_data,
  output logic [CWPW-1:0] cwp,
  output logic [NWIN-1:0] wim,
  output logic            trap_ovf,
  output logic            trap_unf
);
  logic [CWPW-1:0] cwp_dn, cwp_up, cwp_nx;
  logic [NWIN-1:0] wim_nx;
  logic            up_req;
  win_op_e         op;

  always_comb begin
    cwp_dn   = cwp - CWPW'(1);
    cwp_up   = cwp + CWPW'(1);
    up_req   = restore & ~save;
    trap_ovf = save & wim[cwp_dn];
    trap_unf = up_req & wim[cwp_up];
    if (ld_cwp)                op = WIN_LOAD;
    else if (save & ~trap_ovf) op = WIN_DOWN;
    else if (up_req & ~trap_unf) op = WIN_UP;
    else                       op = WIN_HOLD;
    case (op)
      WIN_LOAD: cwp_nx = ld_data[CWPW-1:0];
      WIN_DOWN: cwp_nx = cwp_dn;
      WIN_UP:   cwp_nx = cwp_up;
      default:  cwp_nx = cwp;
    endcase
    wim_nx = ld_wim ? ld_data : wim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= CWPW'(NWIN - 1);
      wim <= '0;
    end else begin
      cwp <= cwp_nx;
      wim <= wim_nx;
    end
  end
endmodule

// File: rtl/regwin_store.sv
module regwin_store
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned NPHYS = NGLOBAL + WINSTEP * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [PW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][PW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [NPHYS];
  logic            we_eff;

  assign we_eff = we & (waddr != '0);

  always_ff @(posedge clk) begin
    if (we_eff) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                    rdata[p] = '0;
      else if (we_eff && waddr == raddr[p])  rdata[p] = wdata;
      else                                   rdata[p] = mem[raddr[p]];
    end
  end
endmodule

// File: rtl/regwin_rf.sv
module regwin_rf
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CWPW  = $clog2(NWIN),
  localparam int unsigned NPHYS = NGLOBAL + WINSTEP * NWIN,
  localparam int unsigned PW    = $clog2(NPHYS),
  localparam int unsigned NRD   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            win_save,
  input  logic            win_restore,
  output logic            trap_ovf,
  output logic            trap_unf,
  input  logic            ctl_wr_cwp,
  input  logic            ctl_wr_wim,
  input  logic [NWIN-1:0] ctl_wdata,
  output logic [CWPW-1:0] cwp_o,
  output logic [NWIN-1:0] wim_o
);
  logic [1:0]                rst_sync;
  logic                      rst_q;
  logic [NRD-1:0][AW-1:0]    rarch;
  logic [NRD-1:0][PW-1:0]    rphys;
  logic [NRD-1:0][XLEN-1:0]  rdat;
  logic [PW-1:0]             wphys;
  logic                      wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  regwin_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rst_n(rst_q), .save(win_save), .restore(win_restore),
    .ld_cwp(ctl_wr_cwp), .ld_wim(ctl_wr_wim), .ld_data(ctl_wdata),
    .cwp(cwp_o), .wim(wim_o), .trap_ovf(trap_ovf), .trap_unf(trap_unf)
  );

  assign rarch[0] = rd_a_addr;
  assign rarch[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    regwin_map #(.NWIN(NWIN)) u_map (
      .arch(rarch[p]), .cwp(cwp_o), .phys(rphys[p])
    );
  end

  regwin_map #(.NWIN(NWIN)) u_wmap (
    .arch(wr_addr), .cwp(cwp_o), .phys(wphys)
  );

  assign wr_go = wr_en & ~trap_ovf & ~trap_unf;

  regwin_store #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) u_store (
    .clk(clk), .we(wr_go), .waddr(wphys), .wdata(wr_data),
    .raddr(rphys), .rdata(rdat)
  );

  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];
endmodule

// File: rtl/regwin_rf_chk.sv
module regwin_rf_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CWPW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_q,
  input logic [4:0]      rd_a_addr,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_addr,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [4:0]      wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            win_save,
  input logic            win_restore,
  input logic            trap_ovf,
  input logic            trap_unf,
  input logic            ctl_wr_cwp,
  input logic [CWPW-1:0] cwp_o
);
  a_r2_zero_a: assert property (@(posedge clk) disable iff (!rst_q)
    rd_a_addr == 5'd0 |-> rd_a_data == '0);
  a_r2_zero_b: assert property (@(posedge clk) disable iff (!rst_q)
    rd_b_addr == 5'd0 |-> rd_b_data == '0);
  a_r4_save_moves: assert property (@(posedge clk) disable iff (!rst_q)
    win_save && !trap_ovf && !ctl_wr_cwp |=> cwp_o == $past(cwp_o) - CWPW'(1));
  a_r4_restore_moves: assert property (@(posedge clk) disable iff (!rst_q)
    win_restore && !win_save && !trap_unf && !ctl_wr_cwp
      |=> cwp_o == $past(cwp_o) + CWPW'(1));
  a_r5_trap_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (trap_ovf || trap_unf) && !ctl_wr_cwp |=> $stable(cwp_o));
  a_r5_one_trap: assert property (@(posedge clk) disable iff (!rst_q)
    !(trap_ovf && trap_unf));
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en && !trap_ovf && !trap_unf && wr_addr != 5'd0 && rd_a_addr == wr_addr
      |-> rd_a_data == wr_data);
endmodule

bind regwin_rf regwin_rf_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_q(rst_q), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .win_save(win_save),
  .win_restore(win_restore), .trap_ovf(trap_ovf), .trap_unf(trap_unf),
  .ctl_wr_cwp(ctl_wr_cwp), .cwp_o(cwp_o)
);

// File: tb/tb_regwin_rf.sv
`timescale 1ns/1ps
module tb_regwin_rf;
  localparam int NW = 4;
  localparam int NP = 8 + 16 * NW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, win_save, win_restore, ctl_wr_cwp, ctl_wr_wim;
  logic        trap_ovf, trap_unf;
  logic [NW-1:0] ctl_wdata, wim_o;
  logic [1:0]  cwp_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [NP];

  always #2 clk = ~clk;

  regwin_rf #(.NWIN(NW), .XLEN(32)) dut (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .win_save(win_save),
    .win_restore(win_restore), .trap_ovf(trap_ovf), .trap_unf(trap_unf),
    .ctl_wr_cwp(ctl_wr_cwp), .ctl_wr_wim(ctl_wr_wim), .ctl_wdata(ctl_wdata),
    .cwp_o(cwp_o), .wim_o(wim_o)
  );

  function automatic int ph(int w, int r);
    if (r < 8) return r;
    return 8 + ((w * 16 + r - 8) % (16 * NW));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cwp(int w);
    ctl_wr_cwp = 1'b1;
    ctl_wdata  = NW'(w);
    tick();
    ctl_wr_cwp = 1'b0;
  endtask

  task automatic wr(int w, int r, logic [31:0] v);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = v;
    tick();
    wr_en = 1'b0;
    if (r != 0) model[ph(w, r)] = v;
  endtask

  task automatic rd(string req, int w, int r);
    rd_a_addr = 5'(r); rd_b_addr = 5'(r);
    #1;
    chk(req, rd_a_data, model[ph(w, r)]);
    chk(req, rd_b_data, model[ph(w, r)]);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    wr_en = 0; win_save = 0; win_restore = 0;
    ctl_wr_cwp = 0; ctl_wr_wim = 0; ctl_wdata = '0;
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 cwp in reset", 32'(cwp_o), NW - 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state after release
    chk("R9 cwp", 32'(cwp_o), NW - 1);
    chk("R9 wim", 32'(wim_o), 0);
    chk("R9 traps", {30'd0, trap_ovf, trap_unf}, 0);

    // R3 R1 R2 sweep: unique value in every register of every window
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      for (int r = 1; r < 32; r++) wr(w, r, 32'hA500_0000 | (w << 8) | r);
    end
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      for (int r = 0; r < 32; r++)
        rd(r == 0 ? "R2 zero" : (r < 8 ? "R1 global" : "R3 window"), w, r);
    end

    // R2 write to register 0 discarded
    wr(0, 0, 32'hFFFF_FFFF);
    rd_a_addr = 5'd0; #1;
    chk("R2 write r0", rd_a_data, 32'h0);

    // R3 overlap seen through a save
    set_cwp(1);
    wr(1, 8, 32'h0000_0055);
    win_save = 1'b1; tick(); win_save = 1'b0;
    chk("R4 save from 1", 32'(cwp_o), 0);
    rd_a_addr = 5'd24; #1;
    chk("R3 ins equal caller outs", rd_a_data, 32'h0000_0055);
    // R3 wrap from top window to window 0
    wr(0, 9, 32'h0000_0077);
    set_cwp(NW - 1);
    rd_a_addr = 5'd25; #1;
    chk("R3 wrap", rd_a_data, 32'h0000_0077);

    // R4 stepping from every pointer value
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      win_save = 1'b1; tick(); win_save = 1'b0;
      chk("R4 save", 32'(cwp_o), (w + NW - 1) % NW);
      set_cwp(w);
      win_restore = 1'b1; tick(); win_restore = 1'b0;
      chk("R4 restore", 32'(cwp_o), (w + 1) % NW);
      set_cwp(w);
      win_save = 1'b1; win_restore = 1'b1; tick();
      win_save = 1'b0; win_restore = 1'b0;
      chk("R4 save wins", 32'(cwp_o), (w + NW - 1) % NW);
    end

    // R8 mask load, window 1 invalid
    ctl_wr_wim = 1'b1; ctl_wdata = NW'(2); tick(); ctl_wr_wim = 1'b0;
    chk("R8 wim load", 32'(wim_o), 2);

    // R5 R6 overflow with a write in the same cycle
    set_cwp(2);
    win_save = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'hDEAD_BEEF;
    #1;
    chk("R5 overflow", {30'd0, trap_ovf, trap_unf}, 2);
    @(posedge clk); @(negedge clk);
    win_save = 1'b0; wr_en = 1'b0;
    chk("R5 cwp held", 32'(cwp_o), 2);
    rd("R6 write dropped", 2, 9);

    // R5 R6 underflow
    set_cwp(0);
    win_restore = 1'b1; wr_en = 1'b1; wr_addr = 5'd3; wr_data = 32'h1234_5678;
    #1;
    chk("R5 underflow", {30'd0, trap_ovf, trap_unf}, 1);
    @(posedge clk); @(negedge clk);
    win_restore = 1'b0; wr_en = 1'b0;
    chk("R5 cwp held up", 32'(cwp_o), 0);
    rd("R6 global write dropped", 0, 3);

    // R5 no trap when destination valid
    set_cwp(NW - 1);
    win_save = 1'b1; #1;
    chk("R5 no trap", {30'd0, trap_ovf, trap_unf}, 0);
    @(posedge clk); @(negedge clk);
    win_save = 1'b0;
    chk("R5 save passes", 32'(cwp_o), NW - 2);

    // R7 bypass on both ports
    wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hC0FF_EE01;
    rd_a_addr = 5'd12; rd_b_addr = 5'd12; #1;
    chk("R7 bypass a", rd_a_data, 32'hC0FF_EE01);
    chk("R7 bypass b", rd_b_data, 32'hC0FF_EE01);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    model[ph(NW - 2, 12)] = 32'hC0FF_EE01;
    rd("R7 stored", NW - 2, 12);

    // R8 pointer load beats save
    set_cwp(1);
    win_save = 1'b1; ctl_wr_cwp = 1'b1; ctl_wdata = NW'(3); tick();
    win_save = 1'b0; ctl_wr_cwp = 1'b0;
    chk("R8 load precedence", 32'(cwp_o), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule